// File: doc/BRIEF.md
# Programmable product-term logic block

This block is one configurable AND-array stage of a programmable logic device. It receives 36 routed input signals and uses each one in both true and inverted form, so 72 literals are available to every product term. Each of 87 product terms is the AND of any chosen subset of those literals. The terms have fixed roles. Terms 0 to 79 are general terms, arranged five per cell for 16 cells. Terms 80 to 83 are output-enable terms. Term 84 is the block-wide asynchronous set, term 85 is the block-wide asynchronous reset, and term 86 is the product-term clock.

Every control term has a programmable output inversion. With it, an OR of inputs can be formed in one pass by inverting the literals and the result. Each cell picks one of the two output-enable terms that its half of the block may use. The path from inputs to outputs is purely combinational.

The configuration is shifted in serially, one bit per clock while shift enable is high. It becomes active only when a load strobe copies the shift register into the active store. Until the first load after reset, all output enables and the set and reset outputs are held inactive.

Top module: `pla_block`

## Requirements
- R1: The configuration word is CFG_W = 6287 bits. Fuse bit t*72+l (term t in 0..86, literal l in 0..71) set to 1 puts literal l into term t. Literal l below 36 is in_i[l], and literal l of 36 or more is the inverse of in_i[l-36].
- R2: A term with no fuse bit set evaluates to 1. A term that includes both a literal and its complement evaluates to 0 for every input.
- R3: gen_pt_o[t] carries term t for t in 0..79. cell_sum_o[c] is the OR of terms 5c to 5c+4.
- R4: The bit at 6264+7+c is the enable select of cell c. Cells 8..15 use term 80 (select 0) or term 81 (select 1). Cells 0..7 use term 82 (select 0) or term 83 (select 1).
- R5: Bits 6264 to 6270 are inversion controls for terms 80, 81, 82, 83, 84, 85 and 86, in that order. A 1 inverts that term's output.
- R6: set_o follows term 84 and rst_o follows term 85, each after its inversion. ptclk_o follows term 86 after its inversion.
- R7: On each rising clock edge with shift_en_i high, the shift register takes sdata_i in at bit 0 and moves its other bits up by one. After CFG_W such shifts, the first bit sent sits at bit CFG_W-1. With shift_en_i low the shift register holds.
- R8: A rising edge with load_i high copies the shift register, as it stood before that edge, into the active configuration. Shifting without a load leaves every output unchanged.
- R9: After reset the active configuration is all zero and no configuration is valid. Until the first load, oe_o is 0 and set_o and rst_o are 0. The general terms and the clock term still evaluate from the zero configuration.
- R10: A change on in_i reaches every output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_en_i | input | 1 | Shift one configuration bit in this cycle |
| sdata_i | input | 1 | Serial configuration data, most significant bit first |
| load_i | input | 1 | Copy the shift register into the active configuration |
| in_i | input | 36 | Routed input signals |
| gen_pt_o | output | 80 | General product terms |
| cell_sum_o | output | 16 | Five-term OR per cell |
| oe_o | output | 16 | Per-cell output enable |
| set_o | output | 1 | Asynchronous set term |
| rst_o | output | 1 | Asynchronous reset term |
| ptclk_o | output | 1 | Product-term clock |

## Verification
Term outputs are combinational, so a new in_i is due within the same cycle. The bench drives inputs 2 ns after a rising edge and compares at the falling edge. Directed checks also sample 1 ns after an input change with no edge in between. A load takes effect at the rising edge that samples load_i, so the reference model updates on that edge and the comparison at the next falling edge expects the new configuration. Shifted bits without a load are expected to change nothing at any later falling edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int N_IN   = 36;
  localparam int N_CELL = 16;
  localparam int TPC    = 5;
  localparam int N_OE   = 4;
  localparam int N_POL  = N_OE + 3;

  function automatic int n_term(int n_cell, int tpc);
    return n_cell * tpc + N_POL;
  endfunction

  function automatic int cfg_width(int n_in, int n_cell, int tpc);
    return n_term(n_cell, tpc) * 2 * n_in + N_POL + n_cell;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdata_i,
  input  logic         load_i,
  output logic [W-1:0] cfg_o,
  output logic         valid_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (shift_en_i) begin
      sr_q <= {sr_q[W-2:0], sdata_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      cfg_o   <= sr_q;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pla_and_array.sv
module pla_and_array #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]             in_i,
  input  logic [N_TERM*2*N_IN-1:0]    fuse_i,
  output logic [N_TERM-1:0]           pt_o
);
  localparam int N_LIT = 2 * N_IN;

  logic [N_LIT-1:0] lits;
  assign lits = {~in_i, in_i};

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    // unselected literals are forced to 1 so they drop out of the AND
    assign pt_o[t] = &(lits | ~fuse_i[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/pla_ctrl.sv
module pla_ctrl #(
  parameter int N_CELL = 16,
  parameter int TPC    = 5
) (
  input  logic [N_CELL*TPC+pla_pkg::N_POL-1:0] pt_i,
  input  logic [pla_pkg::N_POL-1:0]            pol_i,
  input  logic [N_CELL-1:0]                    sel_i,
  input  logic                                 valid_i,
  output logic [N_CELL*TPC-1:0]                gen_o,
  output logic [N_CELL-1:0]                    sum_o,
  output logic [N_CELL-1:0]                    oe_o,
  output logic                                 set_o,
  output logic                                 rst_o,
  output logic                                 clk_o
);
  localparam int N_GEN = N_CELL * TPC;
  localparam int N_POL = pla_pkg::N_POL;
  localparam int I_SET = pla_pkg::N_OE;
  localparam int I_RST = I_SET + 1;
  localparam int I_CLK = I_SET + 2;

  logic [N_POL-1:0] ctl;
  logic [N_CELL-1:0] oe_raw;

  assign gen_o = pt_i[N_GEN-1:0];
  assign ctl   = pt_i[N_GEN +: N_POL] ^ pol_i;

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    localparam int BASE = (c >= N_CELL / 2) ? 0 : 2;
    assign sum_o[c]  = |pt_i[c*TPC +: TPC];
    assign oe_raw[c] = sel_i[c] ? ctl[BASE+1] : ctl[BASE];
  end

  assign oe_o  = valid_i ? oe_raw : '0;
  assign set_o = valid_i & ctl[I_SET];
  assign rst_o = valid_i & ctl[I_RST];
  assign clk_o = ctl[I_CLK];
endmodule

// File: rtl/pla_block.sv
module pla_block #(
  parameter int N_IN   = pla_pkg::N_IN,
  parameter int N_CELL = pla_pkg::N_CELL,
  parameter int TPC    = pla_pkg::TPC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_en_i,
  input  logic                   sdata_i,
  input  logic                   load_i,
  input  logic [N_IN-1:0]        in_i,
  output logic [N_CELL*TPC-1:0]  gen_pt_o,
  output logic [N_CELL-1:0]      cell_sum_o,
  output logic [N_CELL-1:0]      oe_o,
  output logic                   set_o,
  output logic                   rst_o,
  output logic                   ptclk_o
);
  localparam int N_POL  = pla_pkg::N_POL;
  localparam int N_TERM = pla_pkg::n_term(N_CELL, TPC);
  localparam int FUSE_W = N_TERM * 2 * N_IN;
  localparam int CFG_W  = pla_pkg::cfg_width(N_IN, N_CELL, TPC);

  logic [CFG_W-1:0]  cfg;
  logic              cfg_valid;
  logic [N_TERM-1:0] pt;

  pla_cfg_store #(.W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en_i),
    .sdata_i    (sdata_i),
    .load_i     (load_i),
    .cfg_o      (cfg),
    .valid_o    (cfg_valid)
  );

  pla_and_array #(.N_IN(N_IN), .N_TERM(N_TERM)) u_arr (
    .in_i   (in_i),
    .fuse_i (cfg[FUSE_W-1:0]),
    .pt_o   (pt)
  );

  pla_ctrl #(.N_CELL(N_CELL), .TPC(TPC)) u_ctl (
    .pt_i    (pt),
    .pol_i   (cfg[FUSE_W +: N_POL]),
    .sel_i   (cfg[FUSE_W+N_POL +: N_CELL]),
    .valid_i (cfg_valid),
    .gen_o   (gen_pt_o),
    .sum_o   (cell_sum_o),
    .oe_o    (oe_o),
    .set_o   (set_o),
    .rst_o   (rst_o),
    .clk_o   (ptclk_o)
  );
endmodule

// File: rtl/pla_block_chk.sv
module pla_block_chk #(
  parameter int N_IN   = pla_pkg::N_IN,
  parameter int N_CELL = pla_pkg::N_CELL,
  parameter int TPC    = pla_pkg::TPC
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_i,
  input logic [N_IN-1:0]       in_i,
  input logic [N_CELL*TPC-1:0] gen_pt_o,
  input logic [N_CELL-1:0]     cell_sum_o,
  input logic [N_CELL-1:0]     oe_o,
  input logic                  set_o,
  input logic                  rst_o,
  input logic                  ptclk_o,
  input logic                  cfg_valid
);
  for (genvar c = 0; c < N_CELL; c++) begin : g_sum
    p_cell_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cell_sum_o[c] == |gen_pt_o[c*TPC +: TPC]);
  end

  p_gate_invalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid |-> (oe_o == '0 && !set_o && !rst_o));

  p_valid_needs_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_valid) |-> $past(load_i));

  p_valid_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid |=> cfg_valid);

  p_hold_without_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (!$stable(in_i) ||
                 ($stable(gen_pt_o) && $stable(oe_o) && $stable(set_o) &&
                  $stable(rst_o) && $stable(ptclk_o))));
endmodule

bind pla_block pla_block_chk #(.N_IN(N_IN), .N_CELL(N_CELL), .TPC(TPC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .in_i       (in_i),
  .gen_pt_o   (gen_pt_o),
  .cell_sum_o (cell_sum_o),
  .oe_o       (oe_o),
  .set_o      (set_o),
  .rst_o      (rst_o),
  .ptclk_o    (ptclk_o),
  .cfg_valid  (cfg_valid)
);

// File: tb/sim_pla_block.sv
`timescale 1ns/1ps
module sim_pla_block;
  localparam int NI    = 36;
  localparam int NC    = 16;
  localparam int NT    = 87;
  localparam int NL    = 72;
  localparam int FW    = NT * NL;
  localparam int CW    = FW + 7 + NC;

  logic clk = 0, rst_n = 0, shift_en = 0, sdata = 0, load = 0;
  logic [NI-1:0] in_v = '0;
  logic [79:0] gen_pt;
  logic [NC-1:0] cell_sum, oe;
  logic set_s, rst_s, ptclk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [CW-1:0] m_sr, m_act, cfg_a, cfg_b, cfg_cur;
  logic m_valid;

  always #10 clk = ~clk;

  pla_block u0 (
    .clk_i(clk), .rst_ni(rst_n), .shift_en_i(shift_en), .sdata_i(sdata),
    .load_i(load), .in_i(in_v), .gen_pt_o(gen_pt), .cell_sum_o(cell_sum),
    .oe_o(oe), .set_o(set_s), .rst_o(rst_s), .ptclk_o(ptclk)
  );

  // reference state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr <= '0; m_act <= '0; m_valid <= 1'b0;
    end else begin
      if (shift_en) m_sr <= {m_sr[CW-2:0], sdata};
      if (load) begin m_act <= m_sr; m_valid <= 1'b1; end
    end
  end

  function automatic logic [NT-1:0] ref_terms(logic [CW-1:0] c, logic [NI-1:0] x);
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) begin
      r[t] = 1'b1;
      for (int l = 0; l < NL; l++)
        if (c[t*NL+l] && ((l < NI) ? !x[l] : x[l-NI])) r[t] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(string tag, logic [CW-1:0] c, logic v);
    logic [NT-1:0] r;
    logic [79:0] eg;
    logic [NC-1:0] es, eo;
    logic [6:0] ctl;
    r = ref_terms(c, in_v);
    eg = r[79:0];
    for (int k = 0; k < 7; k++) ctl[k] = r[80+k] ^ c[FW+k];
    for (int q = 0; q < NC; q++) begin
      es[q] = 1'b0;
      for (int j = 0; j < 5; j++) es[q] = es[q] | r[q*5+j];
      eo[q] = v & ((q >= 8) ? ctl[c[FW+7+q]] : ctl[2 + c[FW+7+q]]);
    end
    chk({tag, "/R1"}, "gen_pt", gen_pt, eg);
    chk({tag, "/R3"}, "cell_sum", cell_sum, es);
    chk({tag, "/R4"}, "oe", oe, eo);
    chk({tag, "/R6"}, "set", set_s, v & ctl[4]);
    chk({tag, "/R6"}, "rst", rst_s, v & ctl[5]);
    chk({tag, "/R5"}, "ptclk", ptclk, ctl[6]);
  endtask

  always @(negedge clk) if (rst_n && !done) compare("cyc", m_act, m_valid);

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic logic [CW-1:0] rand_cfg();
    logic [CW-1:0] c;
    c = '0;
    for (int t = 0; t < NT; t++) begin
      int n;
      n = $urandom % 4;
      for (int j = 0; j < n; j++) c[t*NL + ($urandom % NL)] = 1'b1;
    end
    for (int k = 0; k < 7 + NC; k++) c[FW+k] = $urandom % 2;
    return c;
  endfunction

  task automatic shift_in(logic [CW-1:0] c, bit gaps);
    for (int i = CW - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 8 == 0)) begin
        step(); shift_en = 0; sdata = $urandom % 2;
      end
      step(); shift_en = 1; sdata = c[i];
      if ($urandom % 64 == 0) in_v = {$urandom, $urandom};
    end
    step(); shift_en = 0;
  endtask

  task automatic do_load();
    step(); load = 1;
    step(); load = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    in_v = 36'h5_A5A5_A5A5;
    #45 rst_n = 1;
    #4;
    // R9: zero config, nothing valid
    chk("R9", "oe after reset", oe, '0);
    chk("R9", "set after reset", set_s, 0);
    chk("R9", "rst after reset", rst_s, 0);
    chk("R9", "gen all ones", gen_pt, {80{1'b1}});
    chk("R9", "ptclk zero cfg", ptclk, 1'b1);

    // R2 corner: term 0 holds literal 0 and its complement, term 1 empty
    cfg_a = rand_cfg();
    for (int l = 0; l < NL; l++) begin cfg_a[l] = 1'b0; cfg_a[NL+l] = 1'b0; end
    cfg_a[0] = 1'b1; cfg_a[NI] = 1'b1;
    shift_in(cfg_a, 0);
    chk("R9", "oe before first load", oe, '0);
    do_load();
    cfg_cur = cfg_a;
    for (int k = 0; k < 6; k++) begin
      in_v = {$urandom, $urandom}; #1;
      chk("R2", "both polarities", gen_pt[0], 1'b0);
      chk("R2", "empty term", gen_pt[1], 1'b1);
      step();
    end

    // R10: no clock edge between input change and sampling
    for (int k = 0; k < 8; k++) begin
      step(); in_v = {$urandom, $urandom}; #1;
      compare("R10", cfg_cur, 1'b1);
    end

    // R8: shift a new image, skip the load, outputs stay on the old one
    cfg_b = rand_cfg();
    shift_in(cfg_b, 1);
    for (int k = 0; k < 6; k++) begin
      step(); in_v = {$urandom, $urandom}; #1;
      compare("R8", cfg_a, 1'b1);
    end

    // R7: image shifted with idle gaps arrives intact
    do_load();
    cfg_cur = cfg_b;
    for (int k = 0; k < 6; k++) begin
      step(); in_v = {$urandom, $urandom}; #1;
      compare("R7", cfg_b, 1'b1);
    end

    // R5/R4: all inversions on, all selects on
    cfg_a = rand_cfg();
    for (int k = 0; k < 7 + NC; k++) cfg_a[FW+k] = 1'b1;
    shift_in(cfg_a, 0);
    do_load();
    for (int k = 0; k < 10; k++) begin
      step(); in_v = {$urandom, $urandom}; #1;
      compare("R5", cfg_a, 1'b1);
    end

    // R4: all selects off, inversions off
    cfg_a = rand_cfg();
    for (int k = 0; k < 7 + NC; k++) cfg_a[FW+k] = 1'b0;
    shift_in(cfg_a, 1);
    do_load();
    for (int k = 0; k < 10; k++) begin
      step(); in_v = {$urandom, $urandom}; #1;
      compare("R4", cfg_a, 1'b1);
    end

    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule